// File: doc/BRIEF.md
# Windowed Register File with Overflow and Underflow Traps

This block is a register file whose 32 visible registers are split into four groups of eight. One group, the globals, is common to every context. The other three (ins, locals, outs) come from a ring of physical windows. A current-window pointer selects which window the program sees. Neighbouring windows overlap: the outs of a window are the same storage as the ins of the window after it. A procedure call therefore passes arguments without copying. The caller fills its outs, issues a save, and the callee finds the values in its ins.

A save moves the pointer up by one and a restore moves it down by one, wrapping around the ring. A mask register holds one bit per window, and only supervisor mode may write it. It marks windows that are not resident. A save or restore whose target is masked leaves the pointer where it is and raises a one-cycle overflow or underflow trap pulse. The pulse comes with the number of the target window. A trap handler can then spill or fill that window, change the mask, and, in supervisor mode, load the pointer directly before it resumes. Spilling windows to memory is outside this block.

The design has two combinational read ports and one write port that takes effect on the clock edge. Each port is addressed by a 5-bit register number.

Top module: `wrf_top`

## Requirements
- R1: A synchronous active-high reset sets the current window to 0, clears the mask and both trap outputs, sets trap_win to 0, and zeroes every register.
- R2: Register number 0 always reads as zero, and a write to it has no effect.
- R3: Register numbers 1 to 7 are globals. The same storage is seen from every window.
- R4: Register numbers 8–15 are outs, 16–23 are locals and 24–31 are ins. In window W, in k (number 24+k) is the same register as out k (number 8+k) of window W−1, modulo the window count.
- R5: A save with no masked target and no supervisor pointer write moves the current window from W to W+1. A restore moves it from W to W−1. Both wrap modulo NWIN.
- R6: The mask loads from wim_wdata on a clock edge with wim_we high only when sup_mode is high. Otherwise wim_we has no effect.
- R7: A save whose target window W+1 has its mask bit set leaves the current window unchanged. On the next cycle ovf_trap is 1 and trap_win shows W+1.
- R8: A restore whose target window W−1 has its mask bit set leaves the current window unchanged. On the next cycle unf_trap is 1 and trap_win shows W−1.
- R9: Each trap output is high for exactly one cycle per blocked command. The two are never high together. trap_win keeps its value until the next trap.
- R10: With sup_mode and cwp_we both high, the current window loads from cwp_wdata on the clock edge. This load takes priority over save and restore in the same cycle, and those then have no effect. Without sup_mode, cwp_we is ignored.
- R11: A write in the same cycle as a save or restore goes to the window that was current before the edge.
- R12: A cycle with save_req and restore_req both high neither moves the pointer nor raises a trap.
- R13: Locals are private to each window. A local written in one window is not visible in any other window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | High when the requester runs in supervisor mode |
| rd_addr0 | input | 5 | Register number, read port 0 |
| rd_data0 | output | XLEN | Read data, port 0 (combinational) |
| rd_addr1 | input | 5 | Register number, read port 1 |
| rd_data1 | output | XLEN | Read data, port 1 (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move to the next window |
| restore_req | input | 1 | Move to the previous window |
| wim_we | input | 1 | Mask write strobe (supervisor only) |
| wim_wdata | input | NWIN | New mask, one bit per window |
| cwp_we | input | 1 | Pointer write strobe (supervisor only) |
| cwp_wdata | input | log2(NWIN) | New current-window value |
| ovf_trap | output | 1 | One-cycle pulse: save was blocked |
| unf_trap | output | 1 | One-cycle pulse: restore was blocked |
| trap_win | output | log2(NWIN) | Target window of the last trap |
| cur_win | output | log2(NWIN) | Current window pointer |

## Verification
The assertions check the pointer protocol on every cycle. A blocked command never moves the pointer and reports the right target. An unblocked one steps exactly once with wraparound. The two traps never coincide. Unprivileged mask writes leave the mask alone, and register 0 reads as zero. The register overlap, the privacy of locals, the shared globals and the rule that a write beside a save lands in the old window are all about stored values. They show only through the bench's scenarios and its cycle-by-cycle comparison against a behavioural model of the windows.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Registers per group and the number of visible registers.
    localparam int unsigned GRP      = 8;
    localparam int unsigned VIS_REGS = 4 * GRP;
    // Each window owns its locals and its outs; ins borrow the previous window's outs.
    localparam int unsigned WIN_SPAN = 2 * GRP;
    localparam int unsigned NRD      = 2;
    localparam int unsigned NPORT    = NRD + 1;

    // Group code is the top two bits of a register number.
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] idx;
    } regnum_t;

    typedef enum logic [1:0] {
        WIN_HOLD,
        WIN_SAVE,
        WIN_RESTORE,
        WIN_SET
    } win_op_e;

    function automatic int unsigned phys_count(int unsigned nwin);
        return GRP + nwin * WIN_SPAN;
    endfunction

    function automatic int unsigned win_base(int unsigned w);
        return GRP + w * WIN_SPAN;
    endfunction

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN),
    parameter int PW   = 8
) (
    input  logic [WW-1:0] cwp,
    input  logic [4:0]    rnum,
    output logic [PW-1:0] phys
);
    import wrf_pkg::*;

    regnum_t     rn;
    logic [WW-1:0] prev_win;
    int unsigned slot;

    assign rn       = regnum_t'(rnum);
    // Ins of window W sit in the outs of window W-1 (R4).
    assign prev_win = (cwp == '0) ? WW'(NWIN - 1) : cwp - 1'b1;

    always_comb begin
        unique case (rn.grp)
            GRP_GLOBAL: slot = 32'(rn.idx);
            GRP_LOCAL:  slot = win_base(32'(cwp)) + 32'(rn.idx);
            GRP_OUT:    slot = win_base(32'(cwp)) + GRP + 32'(rn.idx);
            GRP_IN:     slot = win_base(32'(prev_win)) + GRP + 32'(rn.idx);
            default:    slot = 0;
        endcase
        phys = PW'(slot);
    end

endmodule

// File: rtl/wrf_phys_store.sv
module wrf_phys_store #(
    parameter int XLEN  = 32,
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [PW-1:0]             widx,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][PW-1:0]    ridx,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] cells [NPHYS];

    // Physical slot 0 is global 0: never written (R2).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) cells[i] <= '0;
        end else if (we && (widx != '0)) begin
            cells[widx] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (ridx[p] == '0) ? '0 : cells[ridx[p]];
    end

endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup_mode,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            wim_we,
    input  logic [NWIN-1:0] wim_wdata,
    input  logic            cwp_we,
    input  logic [WW-1:0]   cwp_wdata,
    output logic [WW-1:0]   cwp_q,
    output logic [NWIN-1:0] wim_q,
    output logic            ovf_q,
    output logic            unf_q,
    output logic [WW-1:0]   trap_win_q
);
    import wrf_pkg::*;

    win_op_e       op;
    logic [WW-1:0] up_win, down_win, target;
    logic          blocked;

    assign up_win   = (cwp_q == WW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
    assign down_win = (cwp_q == '0) ? WW'(NWIN - 1) : cwp_q - 1'b1;

    // Supervisor pointer load wins (R10); save and restore together cancel (R12).
    always_comb begin
        if (cwp_we && sup_mode)          op = WIN_SET;
        else if (save_req && !restore_req) op = WIN_SAVE;
        else if (restore_req && !save_req) op = WIN_RESTORE;
        else                              op = WIN_HOLD;
    end

    assign target  = (op == WIN_SAVE) ? up_win : down_win;
    assign blocked = wim_q[target];

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q      <= '0;
            wim_q      <= '0;
            ovf_q      <= 1'b0;
            unf_q      <= 1'b0;
            trap_win_q <= '0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            unique case (op)
                WIN_SET: cwp_q <= cwp_wdata;
                WIN_SAVE: begin
                    if (blocked) begin
                        ovf_q      <= 1'b1;   // R7
                        trap_win_q <= target;
                    end else begin
                        cwp_q <= target;      // R5
                    end
                end
                WIN_RESTORE: begin
                    if (blocked) begin
                        unf_q      <= 1'b1;   // R8
                        trap_win_q <= target;
                    end else begin
                        cwp_q <= target;
                    end
                end
                default: ;
            endcase
            if (wim_we && sup_mode) wim_q <= wim_wdata;  // R6
        end
    end

endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int WW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup_mode,
    input  logic [4:0]      rd_addr0,
    output logic [XLEN-1:0] rd_data0,
    input  logic [4:0]      rd_addr1,
    output logic [XLEN-1:0] rd_data1,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            wim_we,
    input  logic [NWIN-1:0] wim_wdata,
    input  logic            cwp_we,
    input  logic [WW-1:0]   cwp_wdata,
    output logic            ovf_trap,
    output logic            unf_trap,
    output logic [WW-1:0]   trap_win,
    output logic [WW-1:0]   cur_win
);
    import wrf_pkg::*;

    localparam int NPHYS = phys_count(NWIN);
    localparam int PW    = $clog2(NPHYS);

    logic [WW-1:0]             cwp_q;
    logic [NWIN-1:0]           wim_q;
    logic [NPORT-1:0][4:0]     port_rnum;
    logic [NPORT-1:0][PW-1:0]  port_phys;
    logic [NRD-1:0][PW-1:0]    rd_phys;
    logic [NRD-1:0][XLEN-1:0]  rd_vals;

    wrf_window_ctl #(.NWIN(NWIN), .WW(WW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .sup_mode   (sup_mode),
        .save_req   (save_req),
        .restore_req(restore_req),
        .wim_we     (wim_we),
        .wim_wdata  (wim_wdata),
        .cwp_we     (cwp_we),
        .cwp_wdata  (cwp_wdata),
        .cwp_q      (cwp_q),
        .wim_q      (wim_q),
        .ovf_q      (ovf_trap),
        .unf_q      (unf_trap),
        .trap_win_q (trap_win)
    );

    // Ports 0..NRD-1 are reads, the last is the write port; all use the
    // pointer value before the edge (R11).
    assign port_rnum[0] = rd_addr0;
    assign port_rnum[1] = rd_addr1;
    assign port_rnum[2] = wr_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN), .WW(WW), .PW(PW)) u_map (
            .cwp (cwp_q),
            .rnum(port_rnum[p]),
            .phys(port_phys[p])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rdsel
        assign rd_phys[p] = port_phys[p];
    end

    wrf_phys_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .widx (port_phys[NRD]),
        .wdata(wr_data),
        .ridx (rd_phys),
        .rdata(rd_vals)
    );

    assign rd_data0 = rd_vals[0];
    assign rd_data1 = rd_vals[1];
    assign cur_win  = cwp_q;

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int WW   = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst,
    input logic            sup_mode,
    input logic            save_req,
    input logic            restore_req,
    input logic            wim_we,
    input logic            cwp_we,
    input logic [WW-1:0]   cwp_wdata,
    input logic [4:0]      rd_addr0,
    input logic [XLEN-1:0] rd_data0,
    input logic            ovf_trap,
    input logic            unf_trap,
    input logic [WW-1:0]   trap_win,
    input logic [WW-1:0]   cur_win,
    input logic [NWIN-1:0] wim
);
    function automatic logic [WW-1:0] ring_up(logic [WW-1:0] w);
        return (w == WW'(NWIN - 1)) ? '0 : w + 1'b1;
    endfunction
    function automatic logic [WW-1:0] ring_down(logic [WW-1:0] w);
        return (w == '0) ? WW'(NWIN - 1) : w - 1'b1;
    endfunction

    logic plain_save, plain_restore, ptr_load;
    assign ptr_load      = cwp_we && sup_mode;
    assign plain_save    = save_req && !restore_req && !ptr_load;
    assign plain_restore = restore_req && !save_req && !ptr_load;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_win == '0) && !ovf_trap && !unf_trap && (wim == '0));

    assert_g0_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr0 == 5'd0) |-> (rd_data0 == '0));

    assert_save_steps_R5: assert property (@(posedge clk) disable iff (rst)
        (plain_save && !wim[ring_up(cur_win)]) |=> (cur_win == ring_up($past(cur_win))) && !ovf_trap);

    assert_restore_steps_R5: assert property (@(posedge clk) disable iff (rst)
        (plain_restore && !wim[ring_down(cur_win)]) |=> (cur_win == ring_down($past(cur_win))) && !unf_trap);

    assert_wim_guard_R6: assert property (@(posedge clk) disable iff (rst)
        (wim_we && !sup_mode) |=> (wim == $past(wim)));

    assert_no_overflow_move_R7: assert property (@(posedge clk) disable iff (rst)
        (plain_save && wim[ring_up(cur_win)]) |=> ovf_trap && (cur_win == $past(cur_win))
                                                  && (trap_win == ring_up($past(cur_win))));

    assert_no_underflow_move_R8: assert property (@(posedge clk) disable iff (rst)
        (plain_restore && wim[ring_down(cur_win)]) |=> unf_trap && (cur_win == $past(cur_win))
                                                      && (trap_win == ring_down($past(cur_win))));

    assert_traps_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap && unf_trap));

    assert_trap_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_trap || unf_trap) |-> $past(save_req || restore_req));

    assert_trapwin_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!ovf_trap && !unf_trap) |-> $stable(trap_win));

    assert_ptr_load_R10: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> (cur_win == $past(cwp_wdata)) && !ovf_trap && !unf_trap);

    assert_both_cancel_R12: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req && !ptr_load) |=> (cur_win == $past(cur_win)) && !ovf_trap && !unf_trap);

endmodule

bind wrf_top wrf_checker #(.NWIN(NWIN), .XLEN(XLEN), .WW(WW)) u_wrf_chk (
    .clk        (clk),
    .rst        (rst),
    .sup_mode   (sup_mode),
    .save_req   (save_req),
    .restore_req(restore_req),
    .wim_we     (wim_we),
    .cwp_we     (cwp_we),
    .cwp_wdata  (cwp_wdata),
    .rd_addr0   (rd_addr0),
    .rd_data0   (rd_data0),
    .ovf_trap   (ovf_trap),
    .unf_trap   (unf_trap),
    .trap_win   (trap_win),
    .cur_win    (cur_win),
    .wim        (wim_q)
);

// File: tb/tb_wrf_top.sv
module tb_wrf_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int XL = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sup_mode = 1'b0;
    logic [4:0]    rd_addr0 = '0, rd_addr1 = '0, wr_addr = '0;
    logic [XL-1:0] rd_data0, rd_data1, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic          wim_we = 1'b0, cwp_we = 1'b0;
    logic [NW-1:0] wim_wdata = '0;
    logic [2:0]    cwp_wdata = '0;
    logic          ovf_trap, unf_trap;
    logic [2:0]    trap_win, cur_win;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrf_top #(.NWIN(NW), .XLEN(XL)) dut (
        .clk(clk), .rst(rst), .sup_mode(sup_mode),
        .rd_addr0(rd_addr0), .rd_data0(rd_data0),
        .rd_addr1(rd_addr1), .rd_data1(rd_data1),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .wim_we(wim_we), .wim_wdata(wim_wdata),
        .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap),
        .trap_win(trap_win), .cur_win(cur_win)
    );

    // Behavioural model: windows as named groups.
    logic [XL-1:0] m_glob [8];
    logic [XL-1:0] m_loc  [NW][8];
    logic [XL-1:0] m_out  [NW][8];
    int            m_cwp, m_tw;
    logic [NW-1:0] m_wim;
    bit            m_ovf, m_unf;

    function automatic logic [XL-1:0] m_read(int r);
        int k = r % 8;
        if (r == 0)  return '0;
        if (r < 8)   return m_glob[k];
        if (r < 16)  return m_out[m_cwp][k];
        if (r < 24)  return m_loc[m_cwp][k];
        return m_out[(m_cwp + NW - 1) % NW][k];
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int k;
        int tgt;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_glob[i] = '0;
            for (int w = 0; w < NW; w++)
                for (int i = 0; i < 8; i++) begin m_loc[w][i] = '0; m_out[w][i] = '0; end
            m_cwp = 0; m_wim = '0; m_tw = 0; m_ovf = 0; m_unf = 0;
            return;
        end
        k = wr_addr % 8;
        if (wr_en && wr_addr != 0) begin
            if (wr_addr < 8)       m_glob[k] = wr_data;
            else if (wr_addr < 16) m_out[m_cwp][k] = wr_data;
            else if (wr_addr < 24) m_loc[m_cwp][k] = wr_data;
            else                   m_out[(m_cwp + NW - 1) % NW][k] = wr_data;
        end
        m_ovf = 0; m_unf = 0;
        if (sup_mode && cwp_we) m_cwp = cwp_wdata;
        else if (save_req && !restore_req) begin
            tgt = (m_cwp + 1) % NW;
            if (m_wim[tgt]) begin m_ovf = 1; m_tw = tgt; end else m_cwp = tgt;
        end else if (restore_req && !save_req) begin
            tgt = (m_cwp + NW - 1) % NW;
            if (m_wim[tgt]) begin m_unf = 1; m_tw = tgt; end else m_cwp = tgt;
        end
        if (sup_mode && wim_we) m_wim = wim_wdata;
    endtask

    // One clock: compare reads before the edge, registers after it.
    task automatic cyc();
        #1;
        if (!rst) begin
            chk(rd_data0 == m_read(rd_addr0), "R3", "rd_data0", rd_data0, m_read(rd_addr0));
            chk(rd_data1 == m_read(rd_addr1), "R4", "rd_data1", rd_data1, m_read(rd_addr1));
        end
        @(posedge clk);
        model_edge();
        #1;
        chk(cur_win == 3'(m_cwp), "R5", "cur_win", cur_win, m_cwp);
        chk(ovf_trap == m_ovf, "R7", "ovf_trap", ovf_trap, m_ovf);
        chk(unf_trap == m_unf, "R8", "unf_trap", unf_trap, m_unf);
        chk(trap_win == 3'(m_tw), "R9", "trap_win", trap_win, m_tw);
    endtask

    task automatic idle();
        wr_en = 0; save_req = 0; restore_req = 0; wim_we = 0; cwp_we = 0; sup_mode = 0;
    endtask

    task automatic do_write(logic [4:0] a, logic [XL-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; cyc(); idle();
    endtask
    task automatic do_save();    save_req = 1; cyc(); idle(); endtask
    task automatic do_restore(); restore_req = 1; cyc(); idle(); endtask
    task automatic set_wim(logic [NW-1:0] m); sup_mode = 1; wim_we = 1; wim_wdata = m; cyc(); idle(); endtask
    task automatic set_cwp(logic [2:0] w); sup_mode = 1; cwp_we = 1; cwp_wdata = w; cyc(); idle(); endtask

    task automatic rd_chk(logic [4:0] a, logic [XL-1:0] exp, string req);
        rd_addr1 = a; #1;
        chk(rd_data1 == exp, req, "read", rd_data1, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1; idle();
        cyc(); cyc();
        rst = 0;
        // R1: reset state
        chk(cur_win == 0 && !ovf_trap && !unf_trap, "R1", "reset ptr/traps", cur_win, 0);
        rd_chk(5'd9, 32'h0, "R1");
        // R2: register 0 ignores writes
        do_write(5'd0, 32'hDEAD_BEEF);
        rd_chk(5'd0, 32'h0, "R2");
        // R3: globals shared across windows
        do_write(5'd5, 32'h55);
        do_save(); do_save(); do_save();
        chk(cur_win == 3, "R5", "three saves", cur_win, 3);
        rd_chk(5'd5, 32'h55, "R3");
        // R13: locals private
        do_write(5'd18, 32'h1234);
        do_restore();
        rd_chk(5'd18, 32'h0, "R13");
        do_save();
        rd_chk(5'd18, 32'h1234, "R13");
        // R4: outs become ins after save, ins back to outs after restore
        do_write(5'd11, 32'hA5);
        do_save();
        rd_chk(5'd27, 32'hA5, "R4");
        do_write(5'd24, 32'h77);
        do_restore();
        rd_chk(5'd8, 32'h77, "R4");
        // R11: write beside save lands in pre-save window
        wr_en = 1; wr_addr = 5'd16; wr_data = 32'hBEEF; save_req = 1; cyc(); idle();
        rd_chk(5'd16, 32'h0, "R11");
        do_restore();
        rd_chk(5'd16, 32'hBEEF, "R11");
        // R10 and R5: pointer load then wrap
        set_cwp(3'd7);
        chk(cur_win == 7, "R10", "pointer load", cur_win, 7);
        do_save();
        chk(cur_win == 0, "R5", "wrap up", cur_win, 0);
        do_restore();
        chk(cur_win == 7, "R5", "wrap down", cur_win, 7);
        // R6: unprivileged mask write ignored
        wim_we = 1; wim_wdata = 8'hFF; cyc(); idle();
        do_save();
        chk(cur_win == 0 && !ovf_trap, "R6", "save after unprivileged mask write", cur_win, 0);
        // R7: overflow trap on masked window 1
        set_wim(8'b0000_0010);
        do_save();
        chk(ovf_trap && cur_win == 0 && trap_win == 1, "R7", "overflow", {ovf_trap, cur_win, trap_win}, {1'b1, 3'd0, 3'd1});
        cyc();
        chk(!ovf_trap && trap_win == 1, "R9", "pulse ends, trap_win holds", {ovf_trap, trap_win}, {1'b0, 3'd1});
        // R8: underflow trap on masked window 7
        set_wim(8'b1000_0000);
        do_restore();
        chk(unf_trap && !ovf_trap && cur_win == 0 && trap_win == 7, "R8", "underflow", {unf_trap, cur_win, trap_win}, {1'b1, 3'd0, 3'd7});
        // R12: both strobes cancel
        set_wim(8'h00);
        save_req = 1; restore_req = 1; cyc(); idle();
        chk(cur_win == 0 && !ovf_trap && !unf_trap, "R12", "both strobes", cur_win, 0);
        // R10: unprivileged pointer write ignored; privileged load beats save
        cwp_we = 1; cwp_wdata = 3'd5; cyc(); idle();
        chk(cur_win == 0, "R10", "unprivileged pointer write", cur_win, 0);
        sup_mode = 1; cwp_we = 1; cwp_wdata = 3'd4; save_req = 1; cyc(); idle();
        chk(cur_win == 4 && !ovf_trap, "R10", "load over save", cur_win, 4);
        // Random traffic compared each cycle against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            rd_addr0 = 5'($urandom); rd_addr1 = 5'($urandom);
            wr_en = ($urandom % 2) == 0; wr_addr = 5'($urandom); wr_data = $urandom;
            save_req = r < 30; restore_req = (r >= 25 && r < 55);
            sup_mode = ($urandom % 2) == 0;
            wim_we = ($urandom % 10) == 0;
            wim_wdata = 8'($urandom) & 8'($urandom);
            cwp_we = ($urandom % 25) == 0; cwp_wdata = 3'($urandom);
            cyc();
        end
        idle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule